// File: doc/BRIEF.md
# Processor Control Register Bank

This block holds the privileged control registers of a processor core. There are 64 indices of 64 bits each. A combinational read port and a single write port select entries by a 6-bit index. On the write side, every entry applies its own filter: a bit mask, a forced bit, a clear-on-write, or a rejection. On the read side, some entries are blocked and report a fault. Software uses the bank from privileged handler code to save scratch state and to set interrupt and mode fields. It also uses the bank to drive translation-buffer maintenance.

Some entries have side effects:

- Reading the faulting-address entry releases an interrupt-status lock.
- Writes to the invalidate entries send one-cycle maintenance commands to the translation buffers. The buffers themselves are outside this block.
- The page-table-entry entry stores its fields apart from one another and reads back in a packed layout. That layout includes the data address-space number that was current when the entry was written.
- A squash input turns any write into a silent no-op. This lets writes from a squashed speculative path drain without effect.

Top module: `ipr_bank`

## Requirements
- R1: On reset every entry reads zero, with two exceptions: index 24 (handler base) loads the parameter `HBASE_RESET`, and index 41 (memory control) loads 0x6. The lock output, `flush_kind` and the flush fields also reset to zero.
- R2: A write to index 25 (restart address) stores the data with bit 1 forced to zero.
- R3: Indices 26 and 27 (asynchronous-trap request and enable) keep only bits 3:0. Index 28 (interrupt level) keeps only bits 4:0.
- R4: Indices 29 (current mode) and 30 (alternate mode) keep only mask 0x18. Index 31 (software interrupt request) keeps mask 0x7FFF0.
- R5: The following entries apply these masks:
  - Index 32 (control/status) keeps 0xFF_FFFF_0300.
  - Indices 33 and 34 (page-table bases) keep bits 63:30.
  - Indices 35 and 36 (cache modes) keep bits 5:0.
  - Index 37 (instruction ASN) keeps 0x7F0.
  - Index 38 (data ASN) keeps bits 63:57.
  - Indices 0 to 23 (scratch), 24 and 41 store all 64 bits.
- R6: Any accepted write to index 39 (exception summary) or index 40 (exception mask) leaves the entry at zero, whatever the data.
- R7: A write to index 42 to 47 (faulting address, interrupt ID, serial receive, memory status, two PTE-temp entries) or 59 to 63 (unknown) raises `wr_fault` in the same cycle and changes no state.
- R8: A read of index 30, 48 to 57 (write-only entries) or 59 to 63 raises `rd_fault` and returns zero. Indices 42 to 47 read as zero without a fault.
- R9: `lock_set` sets `lock_q` on the next edge. A read (`rd_en`) of index 42 clears it on the next edge, and this clear wins over a simultaneous set.
- R10: Index 58 reads as `(W & 0x07FF_FFFF_0000_FF16) | (A << 57)`. Here W is the last word written to index 58, and A is bits 63:57 of index 38 at the time of that write.
- R11: One cycle after an accepted write, `flush_kind` reports the command for that write and returns to 0 in the following cycle unless another invalidate write follows:
  - Index 52 gives kind 1 (data all); index 53 gives kind 2 (data per-process).
  - Index 55 gives kind 4 (instruction all); index 56 gives kind 5 (instruction per-process).
  - Indices 52, 53, 55 and 56 store zero.
- R12: One cycle after an accepted write to index 54, `flush_kind` is 3, `flush_addr` is the data and `flush_asn` is index 38 bits 63:57. For index 57 the kind is 6 and `flush_asn` is index 37 bits 10:4.
- R13: While `squash` is high a write changes no entry, raises no `wr_fault` and emits no flush command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| squash | input | 1 | Discard the current write |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Write refused (same cycle) |
| rd_en | input | 1 | Read request (qualifies side effects) |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data, zero on fault |
| rd_fault | output | 1 | Read refused |
| lock_set | input | 1 | Set the interrupt-status lock |
| lock_q | output | 1 | Interrupt-status lock state |
| flush_kind | output | 3 | Maintenance command, 0 when idle |
| flush_addr | output | 64 | Address for single-address invalidate |
| flush_asn | output | 7 | ASN for single-address invalidate |

## Verification
The hardest case to reach from the ports is the packed page-table-entry view. Its top field comes from the data-ASN entry as it stood at the moment index 58 was written, not at the moment it is read. The stimulus therefore writes index 38, writes index 58, and then rewrites index 38 before the read. The random phase also interleaves writes to both indices with squashed writes, so stale captures show up as mismatches. The lock is driven with a set and a releasing read in the same cycle to expose the priority between them.

// File: rtl/ipr_pkg.sv
// Package: index map, write filters and access rules of the control register bank.
// Assumes 64-bit entries and a 6-bit index space.
package ipr_pkg;

    localparam int DATA_W = 64;
    localparam int IDX_W  = 6;
    localparam int NREG   = 1 << IDX_W;
    localparam int ASN_W  = 7;
    localparam int NSCRATCH = 24;

    localparam logic [IDX_W-1:0] IX_HBASE     = 6'd24;
    localparam logic [IDX_W-1:0] IX_RESTART   = 6'd25;
    localparam logic [IDX_W-1:0] IX_ASTREQ    = 6'd26;
    localparam logic [IDX_W-1:0] IX_ASTEN     = 6'd27;
    localparam logic [IDX_W-1:0] IX_IPL       = 6'd28;
    localparam logic [IDX_W-1:0] IX_CMODE     = 6'd29;
    localparam logic [IDX_W-1:0] IX_AMODE     = 6'd30;
    localparam logic [IDX_W-1:0] IX_SWREQ     = 6'd31;
    localparam logic [IDX_W-1:0] IX_CSR       = 6'd32;
    localparam logic [IDX_W-1:0] IX_IVPT      = 6'd33;
    localparam logic [IDX_W-1:0] IX_DVPT      = 6'd34;
    localparam logic [IDX_W-1:0] IX_ICMODE    = 6'd35;
    localparam logic [IDX_W-1:0] IX_DCMODE    = 6'd36;
    localparam logic [IDX_W-1:0] IX_IASN      = 6'd37;
    localparam logic [IDX_W-1:0] IX_DASN      = 6'd38;
    localparam logic [IDX_W-1:0] IX_EXSUM     = 6'd39;
    localparam logic [IDX_W-1:0] IX_EXMSK     = 6'd40;
    localparam logic [IDX_W-1:0] IX_MEMCTL    = 6'd41;
    localparam logic [IDX_W-1:0] IX_FVA       = 6'd42;
    localparam logic [IDX_W-1:0] IX_RO_LAST   = 6'd47;
    localparam logic [IDX_W-1:0] IX_WO_FIRST  = 6'd48;
    localparam logic [IDX_W-1:0] IX_DINV_ALL  = 6'd52;
    localparam logic [IDX_W-1:0] IX_DINV_PROC = 6'd53;
    localparam logic [IDX_W-1:0] IX_DINV_ADDR = 6'd54;
    localparam logic [IDX_W-1:0] IX_IINV_ALL  = 6'd55;
    localparam logic [IDX_W-1:0] IX_IINV_PROC = 6'd56;
    localparam logic [IDX_W-1:0] IX_IINV_ADDR = 6'd57;
    localparam logic [IDX_W-1:0] IX_PTE       = 6'd58;

    localparam logic [DATA_W-1:0] MEMCTL_RESET = 64'h6;

    typedef enum logic [2:0] {
        FL_NONE   = 3'd0,
        FL_D_ALL  = 3'd1,
        FL_D_PROC = 3'd2,
        FL_D_ADDR = 3'd3,
        FL_I_ALL  = 3'd4,
        FL_I_PROC = 3'd5,
        FL_I_ADDR = 3'd6
    } flush_e;

    typedef struct packed {
        logic [26:0]      ppn;
        logic [3:0]       rd_en;
        logic [3:0]       wr_en;
        logic             flt_rd;
        logic             flt_wr;
        logic             asm_all;
        logic [ASN_W-1:0] asn;
    } pte_t;

    // Read access rule: scratch through memory control except alt mode, read-only group, PTE view.
    function automatic logic idx_readable(input logic [IDX_W-1:0] idx);
        if (idx == IX_AMODE)   return 1'b0;
        if (idx <= IX_RO_LAST) return 1'b1;
        return (idx == IX_PTE);
    endfunction

    // Write access rule: everything up to memory control, plus the write-only group and PTE.
    function automatic logic idx_writable(input logic [IDX_W-1:0] idx);
        if (idx <= IX_MEMCTL) return 1'b1;
        return (idx >= IX_WO_FIRST) && (idx <= IX_PTE);
    endfunction

    // Per-entry write filter: returns the value that is stored.
    function automatic logic [DATA_W-1:0] wr_filter(input logic [IDX_W-1:0] idx,
                                                    input logic [DATA_W-1:0] v);
        case (idx)
            IX_RESTART:               return v & ~64'h2;
            IX_ASTREQ, IX_ASTEN:      return v & 64'hF;
            IX_IPL:                   return v & 64'h1F;
            IX_CMODE, IX_AMODE:       return v & 64'h18;
            IX_SWREQ:                 return v & 64'h7_FFF0;
            IX_CSR:                   return v & 64'hFF_FFFF_0300;
            IX_IVPT, IX_DVPT:         return v & 64'hFFFF_FFFF_C000_0000;
            IX_ICMODE, IX_DCMODE:     return v & 64'h3F;
            IX_IASN:                  return v & 64'h7F0;
            IX_DASN:                  return v & 64'hFE00_0000_0000_0000;
            IX_EXSUM, IX_EXMSK,
            IX_DINV_ALL, IX_DINV_PROC,
            IX_IINV_ALL, IX_IINV_PROC: return '0;
            default:                  return v;
        endcase
    endfunction

    // Split a written word into stored PTE fields, capturing the supplied ASN.
    function automatic pte_t pte_unpack(input logic [DATA_W-1:0] w, input logic [ASN_W-1:0] a);
        pte_t p;
        p.ppn     = w[58:32];
        p.rd_en   = w[11:8];
        p.wr_en   = w[15:12];
        p.flt_rd  = w[1];
        p.flt_wr  = w[2];
        p.asm_all = w[4];
        p.asn     = a;
        return p;
    endfunction

    // Assemble the packed read view from stored fields (ASN overlays the top bits).
    function automatic logic [DATA_W-1:0] pte_pack(input pte_t p);
        logic [DATA_W-1:0] r;
        r = '0;
        r[58:32] = p.ppn;
        r[11:8]  = p.rd_en;
        r[15:12] = p.wr_en;
        r[1]     = p.flt_rd;
        r[2]     = p.flt_wr;
        r[4]     = p.asm_all;
        r[63:57] = r[63:57] | p.asn;
        return r;
    endfunction

endpackage

// File: rtl/ipr_access.sv
// Access decoder: decides whether the current read and write are legal and
// produces the filtered write value. Assumes squash only qualifies writes.
module ipr_access
    import ipr_pkg::*;
(
    input  logic              wr_en,
    input  logic              squash,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              wr_do,
    output logic              wr_fault,
    output logic [DATA_W-1:0] wr_val,
    output logic              rd_ok
);
    logic wr_legal;

    // Classify the write and compute its stored value.
    always_comb begin
        wr_legal = idx_writable(wr_idx);
        wr_do    = wr_en && !squash && wr_legal;
        wr_fault = wr_en && !squash && !wr_legal;
        wr_val   = wr_filter(wr_idx, wr_data);
    end

    // Classify the read.
    always_comb begin
        rd_ok = idx_readable(rd_idx);
    end
endmodule

// File: rtl/ipr_pte_view.sv
// PTE holder: captures fields of a written page-table-entry word together
// with the data ASN current at that time, and serves the packed read view.
module ipr_pte_view
    import ipr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic [ASN_W-1:0]  asn_now,
    output logic [DATA_W-1:0] view
);
    pte_t fields_q;

    // Capture the fields on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)    fields_q <= '0;
        else if (load) fields_q <= pte_unpack(word, asn_now);
    end

    // Present the packed layout.
    always_comb begin
        view = pte_pack(fields_q);
    end

    // R10
    pte_asn_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> view[63:59] == $past(asn_now[6:2]));
    // R10
    pte_low_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (view[4] == $past(word[4])) && (view[2:1] == $past(word[2:1])));
endmodule

// File: rtl/ipr_flush_gen.sv
// Maintenance command generator: turns accepted writes to invalidate entries
// into a one-cycle registered command with address and ASN.
module ipr_flush_gen
    import ipr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_do,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ASN_W-1:0]  dasn,
    input  logic [ASN_W-1:0]  iasn,
    output flush_e            kind,
    output logic [DATA_W-1:0] addr,
    output logic [ASN_W-1:0]  asn
);
    // Register the command; it lasts one cycle unless renewed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind <= FL_NONE;
            addr <= '0;
            asn  <= '0;
        end else begin
            kind <= FL_NONE;
            if (wr_do) begin
                case (wr_idx)
                    IX_DINV_ALL:  kind <= FL_D_ALL;
                    IX_DINV_PROC: kind <= FL_D_PROC;
                    IX_IINV_ALL:  kind <= FL_I_ALL;
                    IX_IINV_PROC: kind <= FL_I_PROC;
                    IX_DINV_ADDR: begin
                        kind <= FL_D_ADDR;
                        addr <= wr_data;
                        asn  <= dasn;
                    end
                    IX_IINV_ADDR: begin
                        kind <= FL_I_ADDR;
                        addr <= wr_data;
                        asn  <= iasn;
                    end
                    default: kind <= FL_NONE;
                endcase
            end
        end
    end

    // R11
    flush_dall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_do && wr_idx == IX_DINV_ALL) |=> kind == FL_D_ALL);
    // R12
    flush_iaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_do && wr_idx == IX_IINV_ADDR) |=> (kind == FL_I_ADDR) && (addr == $past(wr_data)));
    // R11
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_do |=> kind == FL_NONE);
endmodule

// File: rtl/ipr_bank.sv
// Control register bank top: storage for 64 entries, read mux with fault
// and PTE view, interrupt-status lock, and maintenance command outputs.
// Assumes synchronous active-low reset and a combinational read port.
module ipr_bank
    import ipr_pkg::*;
#(
    parameter logic [63:0] HBASE_RESET = 64'h0000_0000_0001_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        squash,
    input  logic        wr_en,
    input  logic [5:0]  wr_idx,
    input  logic [63:0] wr_data,
    output logic        wr_fault,
    input  logic        rd_en,
    input  logic [5:0]  rd_idx,
    output logic [63:0] rd_data,
    output logic        rd_fault,
    input  logic        lock_set,
    output logic        lock_q,
    output logic [2:0]  flush_kind,
    output logic [63:0] flush_addr,
    output logic [6:0]  flush_asn
);
    logic [DATA_W-1:0] regs_q [NREG];
    logic              wr_do;
    logic [DATA_W-1:0] wr_val;
    logic              rd_ok;
    logic [DATA_W-1:0] pte_rd;
    flush_e            fl_kind;
    logic [ASN_W-1:0]  dasn_cur;
    logic [ASN_W-1:0]  iasn_cur;

    ipr_access u_access (
        .wr_en    (wr_en),
        .squash   (squash),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .wr_do    (wr_do),
        .wr_fault (wr_fault),
        .wr_val   (wr_val),
        .rd_ok    (rd_ok)
    );

    // Pick out the ASN fields the side-effect logic depends on.
    always_comb begin
        dasn_cur = regs_q[IX_DASN][63:57];
        iasn_cur = regs_q[IX_IASN][10:4];
    end

    // Entry storage with per-entry reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
            regs_q[IX_HBASE]  <= HBASE_RESET;
            regs_q[IX_MEMCTL] <= MEMCTL_RESET;
        end else if (wr_do) begin
            regs_q[wr_idx] <= wr_val;
        end
    end

    ipr_pte_view u_pte (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_do && (wr_idx == IX_PTE)),
        .word    (wr_data),
        .asn_now (dasn_cur),
        .view    (pte_rd)
    );

    ipr_flush_gen u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_do   (wr_do),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .dasn    (dasn_cur),
        .iasn    (iasn_cur),
        .kind    (fl_kind),
        .addr    (flush_addr),
        .asn     (flush_asn)
    );

    assign flush_kind = fl_kind;

    // Read mux: zero on fault, packed view for the PTE entry.
    always_comb begin
        rd_fault = !rd_ok;
        rd_data  = '0;
        if (rd_ok) rd_data = (rd_idx == IX_PTE) ? pte_rd : regs_q[rd_idx];
    end

    // Interrupt-status lock: a read of the faulting-address entry releases it.
    always_ff @(posedge clk) begin
        if (!rst_n)                           lock_q <= 1'b0;
        else if (rd_en && rd_idx == IX_FVA)   lock_q <= 1'b0;
        else if (lock_set)                    lock_q <= 1'b1;
    end

    // R2
    restart_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[IX_RESTART][1] == 1'b0);
    // R3
    ast_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q[IX_ASTEN][63:4] == '0) && (regs_q[IX_ASTREQ][63:4] == '0));
    // R6
    exsum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !squash && wr_idx == IX_EXSUM) |=> regs_q[IX_EXSUM] == '0);
    // R13
    squash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && squash && wr_idx == IX_IPL) |=> $stable(regs_q[IX_IPL]));
    // R9
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == IX_FVA) |=> !lock_q);
    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> rd_data == '0);
endmodule

// File: tb/ipr_bank_tb.sv
module ipr_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] HB = 64'h0000_0000_0001_0000;
    localparam logic [63:0] PTE_MASK = 64'h07FF_FFFF_0000_FF16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        squash = 0, wr_en = 0, rd_en = 0, lock_set = 0;
    logic [5:0]  wr_idx = 0, rd_idx = 0;
    logic [63:0] wr_data = 0;
    logic        wr_fault, rd_fault, lock_q;
    logic [63:0] rd_data, flush_addr;
    logic [2:0]  flush_kind;
    logic [6:0]  flush_asn;

    int checks = 0, errors = 0;
    logic [63:0] m [64];
    logic [63:0] m_pte;
    logic [6:0]  m_pasn;
    logic        m_lock;

    ipr_bank #(.HBASE_RESET(HB)) u_dut (
        .clk(clk), .rst_n(rst_n), .squash(squash), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_fault(wr_fault), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_fault(rd_fault), .lock_set(lock_set), .lock_q(lock_q),
        .flush_kind(flush_kind), .flush_addr(flush_addr), .flush_asn(flush_asn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit ex_rd_ok(input int i);
        return (i <= 47 && i != 30) || i == 58;
    endfunction

    function automatic bit ex_wr_ok(input int i);
        return (i <= 41) || (i >= 48 && i <= 58);
    endfunction

    function automatic logic [63:0] ex_store(input int i, input logic [63:0] v);
        if (i == 25) return {v[63:2], 1'b0, v[0]};
        if (i == 26 || i == 27) return {60'd0, v[3:0]};
        if (i == 28) return {59'd0, v[4:0]};
        if (i == 29 || i == 30) return {59'd0, v[4:3], 3'd0};
        if (i == 31) return {45'd0, v[18:4], 4'd0};
        if (i == 32) return {24'd0, v[39:16], 6'd0, v[9:8], 8'd0};
        if (i == 33 || i == 34) return {v[63:30], 30'd0};
        if (i == 35 || i == 36) return {58'd0, v[5:0]};
        if (i == 37) return {53'd0, v[10:4], 4'd0};
        if (i == 38) return {v[63:57], 57'd0};
        if (i == 39 || i == 40 || i == 52 || i == 53 || i == 55 || i == 56) return 64'd0;
        return v;
    endfunction

    function automatic logic [63:0] ex_read(input int i);
        if (!ex_rd_ok(i)) return 64'd0;
        if (i == 58) return (m_pte & PTE_MASK) | {m_pasn, 57'd0};
        return m[i];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m[i] = 64'd0;
        m[24] = HB;
        m[41] = 64'h6;
        m_pte = 0; m_pasn = 0; m_lock = 0;
    endtask

    // Write with fault check, model update and flush check one cycle later.
    task automatic do_write(input int i, input logic [63:0] v, input bit sq);
        bit ok;
        logic [2:0] ek;
        logic [6:0] ea;
        ok = ex_wr_ok(i);
        ek = 3'd0;
        ea = 7'd0;
        @(negedge clk);
        wr_en = 1; wr_idx = i[5:0]; wr_data = v; squash = sq;
        #1;
        chk(sq ? "R13 fault" : (ok ? "R7 nofault" : "R7 fault"), {63'd0, wr_fault},
            {63'd0, (!sq && !ok)});
        if (!sq && ok) begin
            case (i)
                52: ek = 3'd1; 53: ek = 3'd2; 55: ek = 3'd4; 56: ek = 3'd5;
                54: begin ek = 3'd3; ea = m[38][63:57]; end
                57: begin ek = 3'd6; ea = m[37][10:4]; end
                default: ek = 3'd0;
            endcase
            if (i == 58) begin m_pte = v; m_pasn = m[38][63:57]; end
            m[i] = ex_store(i, v);
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; squash = 0;
        #1;
        chk("R11 kind", {61'd0, flush_kind}, {61'd0, ek});
        if (ek == 3'd3 || ek == 3'd6) begin
            chk("R12 addr", flush_addr, v);
            chk("R12 asn", {57'd0, flush_asn}, {57'd0, ea});
        end
    endtask

    task automatic do_read(input int i, input bit en, input string req);
        @(negedge clk);
        rd_idx = i[5:0]; rd_en = en;
        #1;
        chk(req, rd_data, ex_read(i));
        chk("R8 rd_fault", {63'd0, rd_fault}, {63'd0, !ex_rd_ok(i)});
        if (en && i == 42) m_lock = 0;
        @(posedge clk);
        @(negedge clk);
        rd_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] all1;
        all1 = '1;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        chk("R1 lock", {63'd0, lock_q}, 64'd0);
        chk("R1 flush", {61'd0, flush_kind}, 64'd0);
        for (int i = 0; i < 64; i++) do_read(i, 0, "R1 reset read");

        // Directed masks and filters.
        do_write(25, all1, 0); do_read(25, 0, "R2 restart");
        do_write(27, all1, 0); do_read(27, 0, "R3 ast");
        do_write(28, all1, 0); do_read(28, 0, "R3 ipl");
        do_write(29, all1, 0); do_read(29, 0, "R4 mode");
        do_write(31, all1, 0); do_read(31, 0, "R4 swreq");
        do_write(32, all1, 0); do_read(32, 0, "R5 csr");
        do_write(33, all1, 0); do_read(33, 0, "R5 vpt");
        do_write(35, all1, 0); do_read(35, 0, "R5 cmode");
        do_write(37, all1, 0); do_read(37, 0, "R5 iasn");
        do_write(39, all1, 0); do_read(39, 0, "R6 exsum");
        do_write(40, 64'h55, 0); do_read(40, 0, "R6 exmsk");
        do_write(44, all1, 0); do_read(44, 0, "R7 ro unchanged");
        do_write(61, all1, 0);
        do_read(30, 0, "R8 alt mode");
        do_read(50, 0, "R8 write-only");

        // PTE view with ASN captured at write time.
        do_write(38, 64'hA500_0000_0000_0000, 0);
        do_write(58, all1, 0);
        do_write(38, 64'h1234_0000_0000_0000, 0);
        do_read(58, 0, "R10 pte view");
        do_write(58, 64'h0123_4567_89AB_CDEF, 0);
        do_read(58, 0, "R10 pte view 2");

        // Flush commands.
        do_write(52, all1, 0); do_write(53, 64'h9, 0);
        do_write(55, 64'h1, 0); do_write(56, 64'h2, 0);
        do_write(54, 64'hDEAD_BEEF_0000_2000, 0);
        do_write(57, 64'h0000_0000_CAFE_0000, 0);

        // Squash.
        do_write(28, 64'h3, 1); do_read(28, 0, "R13 squash ipl");
        do_write(45, all1, 1);
        do_write(52, all1, 1);

        // Lock behaviour.
        @(negedge clk) lock_set = 1;
        @(negedge clk) lock_set = 0;
        #1 chk("R9 set", {63'd0, lock_q}, 64'd1);
        do_read(42, 1, "R9 fva read");
        #1 chk("R9 clear", {63'd0, lock_q}, 64'd0);
        @(negedge clk) lock_set = 1; rd_idx = 6'd42; rd_en = 1;
        @(negedge clk) lock_set = 0; rd_en = 0;
        #1 chk("R9 clear wins", {63'd0, lock_q}, 64'd0);

        // Constrained random phase.
        for (int n = 0; n < 700; n++) begin
            int idx;
            logic [63:0] v;
            idx = int'($urandom_range(63, 0));
            if (n % 5 == 0) idx = 38 + int'($urandom_range(20, 0) == 0 ? 20 : 0);
            v = {$urandom, $urandom};
            if ($urandom_range(1, 0) == 1)
                do_write(idx, v, ($urandom_range(7, 0) == 0));
            else
                do_read(idx, $urandom_range(1, 0) == 1, "R5 random read");
        end
        do_read(58, 0, "R10 final view");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule